// File: doc/BRIEF.md
# Event interrupt aggregation controller

This block gathers a small set of internal status events into sticky flag bits and turns them into one interrupt line for a host controller. Three sources feed it. The first is the combined request of a subordinate lane-processing interrupt controller, which arrives as a level. The second is the busy level of a synchronization controller. The third is a temperature alarm level. Each transition of the busy level is recorded as its own event: one flag marks the start of activity and another marks its end.

The host uses a small register port to read the flags, clear them by writing ones, enable each flag into the interrupt, and pick whether the interrupt pin is active high or active low. The raw request is the OR of every flag that is both set and enabled. The pin drives that request at the chosen polarity.

Top module: `eia_ctrl`

## Requirements
- R1: After reset, all flags read 0, the enable mask reads 0, the polarity bit reads 0 (active high) and `irq_o` is 0.
- R2: Address 0 reads the flags in the low bits: bit 0 is the subordinate request, bit 1 is busy start, bit 2 is busy end and bit 3 is temperature alarm. All higher bits read 0.
- R3: The subordinate request and the temperature alarm are level inputs. Their flag sets at every rising clock edge at which the input is high.
- R4: A 0-to-1 change of `sync_busy_i` sets the busy-start flag (bit 1). The flag first reads 1 on the second rising edge after the change. A level held high afterwards does not set the flag again.
- R5: A 1-to-0 change of `sync_busy_i` sets the busy-end flag (bit 2), with the same two-edge latency and only once per change.
- R6: A flag stays set until the host writes 1 to its bit at address 0. Bits written as 0 are left unchanged.
- R7: If an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: Address 1 holds a read/write enable mask in bits 3:0, with the same bit order as the flags. The raw request is the OR over all bits of flags AND mask.
- R9: Address 2 bit 0 selects the polarity: 0 makes the pin active high and 1 makes it active low. `irq_o` equals the raw request XOR that bit.
- R10: Address 3 reads 0, and a write to it changes no flag, mask or polarity state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_irq_i | input | 1 | Combined request from the subordinate lane-processing interrupt controller |
| sync_busy_i | input | 1 | Busy level of the synchronization controller |
| temp_alarm_i | input | 1 | Temperature alarm level |
| reg_addr_i | input | ADDR_W (2) | Register address |
| reg_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata_i | input | DATA_W (8) | Write data |
| reg_rdata_o | output | DATA_W (8) | Read data for `reg_addr_i` (combinational by default) |
| irq_o | output | 1 | Interrupt pin at the programmed polarity |

## Verification
The assertions assume that `sync_busy_i` is synchronous to `clk`, so the registered copy of it is a clean level with no metastability. They also assume that the register strobe is only ever a single write per cycle to a single address. The stimulus changes every input one time unit after a rising edge. It holds the busy level steady for several cycles before each flag clear, so that no stray edge event lands on top of a clear the bench did not intend to race. Each set-versus-clear race is staged on purpose, one at a time.

// File: rtl/eia_pkg.sv
package eia_pkg;
   localparam int NUM_FLAGS  = 4;
   localparam int FLG_SUB    = 0;
   localparam int FLG_BSTART = 1;
   localparam int FLG_BEND   = 2;
   localparam int FLG_TEMP   = 3;
   localparam int ADR_FLAGS  = 0;
   localparam int ADR_MASK   = 1;
   localparam int ADR_CTRL   = 2;
endpackage

// File: rtl/eia_busy_edge.sv
module eia_busy_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   output logic rise_o,
   output logic fall_o
);
   logic busy_q, busy_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         busy_prev_q <= 1'b0;
      end else begin
         busy_q      <= busy_i;
         busy_prev_q <= busy_q;
      end
   end

   assign rise_o = busy_q & ~busy_prev_q;
   assign fall_o = ~busy_q & busy_prev_q;

   assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
   assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
   assert_rise_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> $past(busy_i));
endmodule

// File: rtl/eia_flag_bank.sv
module eia_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   if (N < 1) begin : g_bad_n
      $error("eia_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
      end
      assign flags_o[i] = flag_q;

      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_o[i]);
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
      assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !clr_i[i]) |=> $stable(flags_o[i]));
   end
endmodule

// File: rtl/eia_regs.sv
module eia_regs #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int N         = 4,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N-1:0]      flags_i,
   output logic [N-1:0]      clr_o,
   output logic [N-1:0]      mask_o,
   output logic              act_low_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(eia_pkg::ADR_FLAGS);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(eia_pkg::ADR_MASK);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(eia_pkg::ADR_CTRL);

   if (DATA_W <= N) begin : g_bad_w
      $error("eia_regs: DATA_W must exceed the flag count");
   end
   if (ADDR_W < 2) begin : g_bad_a
      $error("eia_regs: ADDR_W must be at least 2");
   end

   logic [N-1:0] mask_q;
   logic         act_low_q;
   logic [DATA_W-1:0] rd_next;
   logic unused_wdata;
   assign unused_wdata = ^wdata_i[DATA_W-1:N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         act_low_q <= 1'b0;
      end else if (wr_i) begin
         if (addr_i == A_MASK) mask_q    <= wdata_i[N-1:0];
         if (addr_i == A_CTRL) act_low_q <= wdata_i[0];
      end
   end

   assign clr_o     = (wr_i && addr_i == A_FLAGS) ? wdata_i[N-1:0] : '0;
   assign mask_o    = mask_q;
   assign act_low_o = act_low_q;

   always_comb begin
      rd_next = '0;
      if (addr_i == A_FLAGS)     rd_next[N-1:0] = flags_i;
      else if (addr_i == A_MASK) rd_next[N-1:0] = mask_q;
      else if (addr_i == A_CTRL) rd_next[0]     = act_low_q;
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_next;
      end
      assign rdata_o = rdata_q;
   end else begin : g_rd_comb
      assign rdata_o = rd_next;
   end

   assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_MASK) |=> mask_o == $past(wdata_i[N-1:0]));
   assert_pol_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_CTRL) |=> act_low_o == $past(wdata_i[0]));
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && (addr_i == A_MASK || addr_i == A_CTRL)) |=>
         ($stable(mask_o) && $stable(act_low_o)));
endmodule

// File: rtl/eia_ctrl.sv
module eia_ctrl #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_irq_i,
   input  logic              sync_busy_i,
   input  logic              temp_alarm_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   localparam int N = eia_pkg::NUM_FLAGS;

   logic         busy_rise, busy_fall;
   logic [N-1:0] set_vec, clr_vec, flags, mask;
   logic         act_low, raw_req;

   eia_busy_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (sync_busy_i),
      .rise_o (busy_rise),
      .fall_o (busy_fall)
   );

   always_comb begin
      set_vec = '0;
      set_vec[eia_pkg::FLG_SUB]    = sub_irq_i;
      set_vec[eia_pkg::FLG_BSTART] = busy_rise;
      set_vec[eia_pkg::FLG_BEND]   = busy_fall;
      set_vec[eia_pkg::FLG_TEMP]   = temp_alarm_i;
   end

   eia_flag_bank #(.N(N)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .flags_o (flags)
   );

   eia_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .N         (N),
      .RDATA_REG (RDATA_REG)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (reg_addr_i),
      .wr_i      (reg_wr_i),
      .wdata_i   (reg_wdata_i),
      .flags_i   (flags),
      .clr_o     (clr_vec),
      .mask_o    (mask),
      .act_low_o (act_low),
      .rdata_o   (reg_rdata_o)
   );

   assign raw_req = |(flags & mask);
   assign irq_o   = raw_req ^ act_low;

   assert_no_irq_without_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> (irq_o == act_low));
   assert_temp_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      temp_alarm_i |=> flags[eia_pkg::FLG_TEMP]);
endmodule

// File: tb/sim_eia_ctrl.sv
`timescale 1ns/1ps
module sim_eia_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_irq = 1'b0, busy = 1'b0, temp = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   int         n_cmp = 0, n_bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   eia_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sub_irq_i(sub_irq), .sync_busy_i(busy),
      .temp_alarm_i(temp), .reg_addr_i(addr), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick();
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic make_pat(input logic [3:0] p);
      if (p[1]) busy = 1'b0;
      else if (p[2]) busy = 1'b1;
      tick(3);
      wr_reg(2'd0, 8'h0F);
      if (p[0]) sub_irq = 1'b1;
      if (p[3]) temp = 1'b1;
      if (p[1]) busy = 1'b1;
      tick();
      sub_irq = 1'b0; temp = 1'b0;
      if (p[1] && p[2]) begin
         tick(2);
         busy = 1'b0;
      end else if (p[2]) begin
         busy = 1'b0;
      end
      tick(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      tick(3);
      // R1: state during and after reset
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      tick(2);
      rd_reg(2'd0, v); chk("R1 flags", v, 8'h00);
      rd_reg(2'd1, v); chk("R1 mask", v, 8'h00);
      rd_reg(2'd2, v); chk("R1 ctrl", v, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);

      // R3: level inputs set their flag
      sub_irq = 1'b1; tick(); sub_irq = 1'b0;
      rd_reg(2'd0, v); chk("R3 sub", v, 8'h01);
      temp = 1'b1; tick(); temp = 1'b0;
      rd_reg(2'd0, v); chk("R3 temp", v, 8'h09);
      wr_reg(2'd0, 8'hFF);
      rd_reg(2'd0, v); chk("R6 clear all", v, 8'h00);

      // R4: rising busy, two-edge latency, single set
      busy = 1'b1;
      tick(); rd_reg(2'd0, v); chk("R4 early", v, 8'h00);
      tick(); rd_reg(2'd0, v); chk("R4 set", v, 8'h02);
      wr_reg(2'd0, 8'h02);
      tick(5); rd_reg(2'd0, v); chk("R4 once", v, 8'h00);

      // R5: falling busy
      busy = 1'b0;
      tick(); rd_reg(2'd0, v); chk("R5 early", v, 8'h00);
      tick(); rd_reg(2'd0, v); chk("R5 set", v, 8'h04);
      wr_reg(2'd0, 8'h04);
      tick(5); rd_reg(2'd0, v); chk("R5 once", v, 8'h00);

      // R6: selective clear
      make_pat(4'hF);
      rd_reg(2'd0, v); chk("R6 all set", v, 8'h0F);
      wr_reg(2'd0, 8'h05);
      rd_reg(2'd0, v); chk("R6 partial clear", v, 8'h0A);

      // R7: event beats clear in the same cycle
      wr_reg(2'd0, 8'h0F);
      temp = 1'b1;
      wr_reg(2'd0, 8'h08);
      temp = 1'b0;
      rd_reg(2'd0, v); chk("R7 set wins", v, 8'h08);
      wr_reg(2'd0, 8'h08);
      rd_reg(2'd0, v); chk("R7 later clear", v, 8'h00);

      // R10: unmapped address
      wr_reg(2'd1, 8'h05);
      make_pat(4'h3);
      wr_reg(2'd3, 8'hFF);
      rd_reg(2'd3, v); chk("R10 read zero", v, 8'h00);
      rd_reg(2'd1, v); chk("R10 mask kept", v, 8'h05);
      rd_reg(2'd2, v); chk("R10 ctrl kept", v, 8'h00);
      rd_reg(2'd0, v); chk("R10 flags kept", v, 8'h03);

      // R2/R8/R9: sweep all flag patterns, masks and polarities
      for (int p = 0; p < 16; p++) begin
         make_pat(p[3:0]);
         rd_reg(2'd0, v); chk("R2 pattern", v, {4'd0, p[3:0]});
         for (int m = 0; m < 16; m++) begin
            wr_reg(2'd1, {4'd0, m[3:0]});
            rd_reg(2'd1, v); chk("R8 mask readback", v, {4'd0, m[3:0]});
            for (int pol = 0; pol < 2; pol++) begin
               wr_reg(2'd2, {7'd0, pol[0]});
               chk("R9 irq", {7'd0, irq},
                   {7'd0, ((p[3:0] & m[3:0]) != 4'd0) ^ pol[0]});
            end
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule